// File: doc/BRIEF.md
# Parking Occupancy Gate Controller

This block keeps a running count of the cars inside a parking area. An entrance sensor and an exit sensor arrive as synchronous level signals. Each one is turned into a single-cycle event on its rising edge, so a car that holds a sensor high for many cycles is counted once. Entry events add one to the count and exit events take one away. The count saturates at zero and at the configured capacity.

The count is brought out for a display. A full flag and its inverse, an available flag, show whether the lot has room. A gate command raises the entrance barrier for a fixed number of cycles after each entry that is admitted. Entries that arrive while the lot is full are refused, and the barrier stays down for them. Display segment driving, the gate motor and sensor debouncing are handled outside this block.

Top module: `park_gate_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `count_o` is 0, `gate_open_o` is 0, `full_o` is 0 and `avail_o` is 1.
- R2: A rising edge on `entry_i` (low in the previous cycle, high now) with no exit event and the lot not full raises `count_o` by exactly 1 at the next clock edge. Holding `entry_i` high produces no further increments.
- R3: A rising edge on `exit_i` with no entry event and `count_o` above 0 lowers `count_o` by exactly 1 at the next clock edge.
- R4: When an entry event and an exit event occur in the same cycle, `count_o` is unchanged.
- R5: `full_o` is 1 exactly when `count_o` equals `CAPACITY`, and `avail_o` is always the inverse of `full_o`.
- R6: An entry event while `full_o` is 1 leaves `count_o` unchanged and does not raise the gate.
- R7: An exit event while `count_o` is 0 leaves `count_o` at 0.
- R8: An admitted entry (an entry event while not full) sets `gate_open_o` to 1 from the next clock edge for exactly `GATE_CYCLES` cycles. A further admitted entry during that window restarts the full window.
- R9: `count_o` never exceeds `CAPACITY`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| entry_i | input | 1 | Entrance sensor level, synchronous |
| exit_i | input | 1 | Exit sensor level, synchronous |
| count_o | output | $clog2(CAPACITY+1) | Current occupancy count for the display |
| full_o | output | 1 | Lot is at capacity |
| avail_o | output | 1 | Lot has room |
| gate_open_o | output | 1 | 1 raises the entrance barrier, 0 lowers it |

## Verification
Every result is due one clock edge after the stimulus. A sensor edge seen in a cycle moves `count_o`, `full_o` and `avail_o` at the next rising clock edge. An admitted entry raises `gate_open_o` at that same edge, and the gate falls `GATE_CYCLES` edges later. The bench changes its inputs on falling clock edges and samples the outputs on the following falling edge. Each check therefore sees the state exactly one register stage after the stimulus. The gate window is measured by counting sampled cycles from that first edge.

// File: rtl/park_pkg.sv
package park_pkg;
  typedef enum int unsigned {
    SNS_ENTRY = 0,
    SNS_EXIT  = 1
  } sensor_e;

  localparam int unsigned NUM_SENSORS = 2;
endpackage

// File: rtl/park_edge_det.sv
module park_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign pulse_o = level_i & ~level_q;

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/park_occ_counter.sv
module park_occ_counter #(
  parameter int unsigned CAPACITY = 20,
  localparam int unsigned CNT_W = $clog2(CAPACITY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(CAPACITY);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty;

  assign full  = (cnt_q == CAP);
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc_i, dec_i})
      2'b10:   if (!full)  cnt_d = cnt_q + ONE;
      2'b01:   if (!empty) cnt_d = cnt_q - ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign full_o  = full;
  assign empty_o = empty;

  // R9
  cnt_le_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CAP);
  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && cnt_q != CAP) |=> cnt_q == $past(cnt_q) + ONE);
  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  // R4
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(cnt_q));
  // R6
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q == CAP && !dec_i) |=> $stable(cnt_q));
  // R7
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && cnt_q == '0 && !inc_i) |=> cnt_q == '0);
endmodule

// File: rtl/park_gate_timer.sv
module park_gate_timer #(
  parameter int unsigned GATE_CYCLES = 16,
  localparam int unsigned TMR_W = $clog2(GATE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic gate_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tmr_q <= '0;
    else if (load_i)       tmr_q <= TMR_W'(GATE_CYCLES);
    else if (tmr_q != '0)  tmr_q <= tmr_q - TMR_W'(1);
  end

  assign gate_o = (tmr_q != '0);

  // R8
  gate_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> gate_o);
  // R8
  gate_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !gate_o) |=> !gate_o);
endmodule

// File: rtl/park_gate_ctrl.sv
module park_gate_ctrl #(
  parameter int unsigned CAPACITY    = 20,
  parameter int unsigned GATE_CYCLES = 16,
  localparam int unsigned CNT_W = $clog2(CAPACITY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic             exit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             avail_o,
  output logic             gate_open_o
);
  import park_pkg::*;

  logic [NUM_SENSORS-1:0] level, pulse;
  logic                   full, empty, admit;

  assign level[SNS_ENTRY] = entry_i;
  assign level[SNS_EXIT]  = exit_i;

  for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_sns
    park_edge_det u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (level[g]),
      .pulse_o (pulse[g])
    );
  end

  park_occ_counter #(.CAPACITY(CAPACITY)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (pulse[SNS_ENTRY]),
    .dec_i   (pulse[SNS_EXIT]),
    .cnt_o   (count_o),
    .full_o  (full),
    .empty_o (empty)
  );

  // a car is let in whenever there is room, even if another leaves in the same cycle
  assign admit = pulse[SNS_ENTRY] & ~full;

  park_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (admit),
    .gate_o (gate_open_o)
  );

  assign full_o  = full;
  assign avail_o = ~full;

  // R6
  full_no_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse[SNS_ENTRY] && full_o && !gate_open_o) |=> !gate_open_o);
  // R5
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({full_o, avail_o}));
  // R7
  empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !full_o);
endmodule

// File: tb/park_gate_ctrl_test.sv
module park_gate_ctrl_test;
  localparam int unsigned CAP  = 3;
  localparam int unsigned GCYC = 4;
  localparam int unsigned CW   = $clog2(CAP + 1);
  localparam int NVEC = 23;

  // {entry, exit, expected count[1:0]}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b10_01, 4'b00_01, 4'b10_10, 4'b10_10, 4'b00_10,
    4'b01_01, 4'b00_01, 4'b11_01, 4'b00_01, 4'b10_10,
    4'b00_10, 4'b10_11, 4'b00_11, 4'b10_11, 4'b00_11,
    4'b01_10, 4'b00_10, 4'b01_01, 4'b00_01, 4'b01_00,
    4'b00_00, 4'b01_00, 4'b00_00
  };

  logic clk = 1'b0, rst_n = 1'b0, entry = 1'b0, exit_s = 1'b0;
  logic [CW-1:0] count;
  logic full, avail, gate;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  park_gate_ctrl #(.CAPACITY(CAP), .GATE_CYCLES(GCYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .entry_i(entry), .exit_i(exit_s),
    .count_o(count), .full_o(full), .avail_o(avail), .gate_open_o(gate)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic en, logic ex);
    entry = en; exit_s = ex;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 count in reset", int'(count), 0);
    chk("R1 gate in reset", int'(gate), 0);
    chk("R1 avail in reset", int'(avail), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after release", int'(count), 0);

    // table walk: R2 R3 R4 R6 R7 R5
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][3], VEC[i][2]);
      chk("R2/R3/R4/R6/R7 count", int'(count), int'(VEC[i][1:0]));
      chk("R5 full", int'(full), int'(VEC[i][1:0] == 2'(CAP)));
      chk("R5 avail", int'(avail), int'(VEC[i][1:0] != 2'(CAP)));
    end

    // R8 gate window
    repeat (GCYC + 2) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R8 gate first cycle", int'(gate), 1);
    for (int k = 1; k < int'(GCYC); k++) begin
      step(1'b0, 1'b0);
      chk("R8 gate held", int'(gate), 1);
    end
    step(1'b0, 1'b0);
    chk("R8 gate closed", int'(gate), 0);

    // R8 retrigger: count now 1
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);  // count 3, restart window
    for (int k = 0; k < int'(GCYC); k++) begin
      chk("R8 retrigger held", int'(gate), 1);
      step(1'b0, 1'b0);
    end
    chk("R8 retrigger closed", int'(gate), 0);
    chk("R5 full at cap", int'(full), 1);

    // R6 entry while full: no gate, no change
    step(1'b1, 1'b0);
    chk("R6 gate stays low", int'(gate), 0);
    chk("R6 count held", int'(count), int'(CAP));
    step(1'b0, 1'b0);
    chk("R6 gate still low", int'(gate), 0);

    // R4 entry+exit when full: net zero, car admitted? no room -> gate low
    step(1'b1, 1'b1);
    chk("R4 both at full", int'(count), int'(CAP));

    // R1 asynchronous reset mid-run
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk("R3 exit from full", int'(count), int'(CAP) - 1);
    #2 rst_n = 1'b0;
    #1 chk("R1 async clear", int'(count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    exit_s = 1'b0;
    @(negedge clk);
    chk("R1 gate after reset", int'(gate), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule